// File: doc/BRIEF.md
# Reverse Zig-Zag Coefficient Analyzer

This block sits between a residual coefficient buffer and the variable-length coding stages of a video entropy encoder. On a start pulse it walks one quantized residual block from its highest-frequency position down toward DC, fetching exactly one coefficient per clock from the buffer's read port and looking at each value only once. While it walks, it builds every statistic the later coding stages need: the number of non-zero coefficients, the number of trailing unit-magnitude values and their signs, the total of zeros that lie below the highest non-zero coefficient, the number of remaining levels, a file of those levels, and a file of zero runs.

The length and order of the walk depend on the block kind. A full 4x4 block is read in reverse zig-zag order over all 16 positions. An AC-only 4x4 block uses the same order but stops before the DC position, so it takes 15 reads. A 2x2 chroma DC block is read in reverse raster order in 4 reads. The buffer port is combinational: the address and the data belong to the same cycle.

The controller has three states. ST_IDLE waits; a start moves it to ST_SCAN. ST_SCAN issues one read per cycle and moves to ST_DONE after the last read. ST_DONE lasts one cycle and drives done; from there a start goes back to ST_SCAN and its absence returns to ST_IDLE. A start seen in ST_SCAN is dropped.

Top module: `coef_scan_analyzer`

## Requirements
- R1: After reset, done and rd_en are 0 and total_coeff, trailing_ones, total_zeros, level_cnt, t1_signs, level_file and run_file are all zero.
- R2: blk_kind 0 (full block) gives 16 reads on consecutive cycles at raster addresses (row*4+col) 15,14,11,7,10,13,12,9,6,3,2,5,8,4,1,0 in that order; blk_kind 3 behaves the same as 0.
- R3: blk_kind 1 (AC-only block) gives 15 reads in the order of R2 without the final address 0; the value at address 0 has no effect.
- R4: blk_kind 2 (2x2 DC block) gives 4 reads at addresses 3,2,1,0; values at addresses 4 to 15 have no effect.
- R5: rd_en is high in exactly the read cycles of a scan, starting the cycle after the accepted start, one address per cycle, each address once.
- R6: total_coeff equals the number of non-zero values read (rd_data is two's complement).
- R7: trailing_ones counts the ±1 values met among the non-zero values, in read order, until the first non-zero value of magnitude above 1 or until three have been counted; t1_signs bit i is 1 when the i-th such value is -1.
- R8: Every other non-zero value is stored in level_file entry j in read order (j from 0); level_cnt is their number, so trailing_ones + level_cnt = total_coeff; unused entries stay zero.
- R9: total_zeros counts the zeros read after the first non-zero value; zeros read before it are not counted.
- R10: run_file entry j holds the zeros read between the j-th non-zero value (in read order, from 0) and the next non-zero value, or the end of the scan for the last one; unused entries stay zero.
- R11: done is high for exactly one cycle, the cycle after the last read, and all results hold their values until the next accepted start.
- R12: A start pulse during a scan is ignored: the read sequence and the results are those of the original block kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan (accepted outside ST_SCAN) |
| blk_kind | input | 2 | 0 full, 1 AC-only, 2 2x2 DC, 3 as full |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | 4 | Buffer raster address |
| rd_data | input | COEF_W | Coefficient at rd_addr, same cycle |
| done | output | 1 | One-cycle pulse when results are complete |
| total_coeff | output | 5 | Non-zero count |
| trailing_ones | output | 2 | Trailing ±1 count |
| total_zeros | output | 5 | Zeros below the highest non-zero value |
| level_cnt | output | 5 | Number of stored levels |
| t1_signs | output | 3 | Trailing ±1 signs, 1 = negative |
| level_file | output | 16 x COEF_W | Stored levels, entry 0 first |
| run_file | output | 16 x 4 | Zero runs per non-zero value |

## Verification
A wrong scan position or block-kind register shows at once on rd_addr during the read cycles and as a wrong done latency, since done should rise exactly one cycle after the 16th, 15th or 4th read. A corrupted trailing-one or level counter shows when done rises, as a count that disagrees with total_coeff or as a level landing in the wrong file entry. Errors in the zero-run logic appear only at done, in total_zeros and run_file, so vectors with leading zeros, zeros between values and zeros running to the scan end are used to expose them.

// File: rtl/rzz_pkg.sv
package rzz_pkg;

    typedef enum logic [1:0] {
        KIND_FULL = 2'd0,
        KIND_AC   = 2'd1,
        KIND_DC   = 2'd2,
        KIND_ALT  = 2'd3
    } blk_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

    // zig-zag scan position -> raster index of a 4x4 block
    function automatic logic [3:0] zz_raster(input logic [3:0] p);
        logic [3:0] r;
        case (p)
            4'd0:  r = 4'd0;
            4'd1:  r = 4'd1;
            4'd2:  r = 4'd4;
            4'd3:  r = 4'd8;
            4'd4:  r = 4'd5;
            4'd5:  r = 4'd2;
            4'd6:  r = 4'd3;
            4'd7:  r = 4'd6;
            4'd8:  r = 4'd9;
            4'd9:  r = 4'd12;
            4'd10: r = 4'd13;
            4'd11: r = 4'd10;
            4'd12: r = 4'd7;
            4'd13: r = 4'd11;
            4'd14: r = 4'd14;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rzz_addr_map.sv
module rzz_addr_map
    import rzz_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  blk_kind_e         kind,
    input  logic [POS_W-1:0]  pos,
    output logic [POS_W-1:0]  addr
);

    always_comb begin
        if (kind == KIND_DC) begin
            addr = pos;
        end else begin
            addr = zz_raster(pos);
        end
    end

endmodule

// File: rtl/rzz_coef_class.sv
module rzz_coef_class #(
    parameter int COEF_W = 16
) (
    input  logic [COEF_W-1:0] coef,
    output logic              is_zero,
    output logic              is_unit,
    output logic              is_neg
);

    always_comb begin
        is_zero = (coef == '0);
        is_unit = (coef == COEF_W'(1)) || (coef == '1);
        is_neg  = coef[COEF_W-1];
    end

endmodule

// File: rtl/coef_scan_analyzer.sv
module coef_scan_analyzer
    import rzz_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    blk_kind,
    output logic                          rd_en,
    output logic [3:0]                    rd_addr,
    input  logic [COEF_W-1:0]             rd_data,
    output logic                          done,
    output logic [4:0]                    total_coeff,
    output logic [1:0]                    trailing_ones,
    output logic [4:0]                    total_zeros,
    output logic [4:0]                    level_cnt,
    output logic [2:0]                    t1_signs,
    output logic [15:0][COEF_W-1:0]       level_file,
    output logic [15:0][3:0]              run_file
);

    localparam int BLK_N  = 16;
    localparam int DC_N   = 4;
    localparam int POS_W  = $clog2(BLK_N);
    localparam int CNT_W  = $clog2(BLK_N + 1);
    localparam logic [1:0] T1_MAX = 2'd3;

    scan_state_e         state, state_nx;
    blk_kind_e           kind_q;
    logic [POS_W-1:0]    pos;
    logic [POS_W-1:0]    last_pos;
    logic                last_rd;
    logic                accept;
    logic [POS_W-1:0]    run_cnt;
    logic                t1_open;
    logic                c_zero, c_unit, c_neg;
    logic [POS_W-1:0]    tc_idx, prev_idx, lvl_idx;

    assign accept   = start && (state != ST_SCAN);
    assign last_pos = (kind_q == KIND_AC) ? POS_W'(1) : '0;
    assign last_rd  = (pos == last_pos);
    assign tc_idx   = total_coeff[POS_W-1:0];
    assign prev_idx = POS_W'(total_coeff - CNT_W'(1));
    assign lvl_idx  = level_cnt[POS_W-1:0];

    rzz_addr_map #(.POS_W(POS_W)) u_addr (
        .kind (kind_q),
        .pos  (pos),
        .addr (rd_addr)
    );

    rzz_coef_class #(.COEF_W(COEF_W)) u_class (
        .coef    (rd_data),
        .is_zero (c_zero),
        .is_unit (c_unit),
        .is_neg  (c_neg)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_SCAN;
            ST_SCAN: if (last_rd) state_nx = ST_DONE;
            ST_DONE: state_nx = start ? ST_SCAN : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register, scan position and latched kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= KIND_FULL;
            pos    <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                kind_q <= blk_kind_e'(blk_kind);
                pos    <= (blk_kind_e'(blk_kind) == KIND_DC) ? POS_W'(DC_N - 1)
                                                             : POS_W'(BLK_N - 1);
            end else if (state == ST_SCAN && !last_rd) begin
                pos <= pos - POS_W'(1);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        rd_en = (state == ST_SCAN);
        done  = (state == ST_DONE);
    end

    // statistics gathered during the reverse pass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_coeff   <= '0;
            trailing_ones <= '0;
            total_zeros   <= '0;
            level_cnt     <= '0;
            t1_signs      <= '0;
            level_file    <= '0;
            run_file      <= '0;
            run_cnt       <= '0;
            t1_open       <= 1'b1;
        end else if (accept) begin
            total_coeff   <= '0;
            trailing_ones <= '0;
            total_zeros   <= '0;
            level_cnt     <= '0;
            t1_signs      <= '0;
            level_file    <= '0;
            run_file      <= '0;
            run_cnt       <= '0;
            t1_open       <= 1'b1;
        end else if (state == ST_SCAN) begin
            if (c_zero) begin
                if (total_coeff != '0) begin
                    run_cnt            <= run_cnt + POS_W'(1);
                    total_zeros        <= total_zeros + CNT_W'(1);
                    run_file[prev_idx] <= run_cnt + POS_W'(1);
                end
            end else begin
                run_cnt          <= '0;
                run_file[tc_idx] <= '0;
                total_coeff      <= total_coeff + CNT_W'(1);
                if (t1_open && c_unit && trailing_ones != T1_MAX) begin
                    t1_signs[trailing_ones] <= c_neg;
                    trailing_ones           <= trailing_ones + 2'd1;
                end else begin
                    t1_open             <= 1'b0;
                    level_file[lvl_idx] <= rd_data;
                    level_cnt           <= level_cnt + CNT_W'(1);
                end
            end
        end
    end

    // ---------------- assertions ----------------
    assert_t1_plus_lvl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(trailing_ones) + int'(level_cnt) == int'(total_coeff));

    assert_zero_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(total_coeff) + int'(total_zeros) <= BLK_N);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !start) |=> ($stable(total_coeff) && $stable(total_zeros)
                                && $stable(level_file) && $stable(run_file)));

    assert_first_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rd_en) |=> rd_en);

    assert_ac_skips_dc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind_q == KIND_AC) |-> rd_addr != 4'd0);

    assert_dc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind_q == KIND_DC) |-> rd_addr < 4'd4);

    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && start) |=> $stable(kind_q));

endmodule

// File: tb/coef_scan_analyzer_bench.sv
module coef_scan_analyzer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    typedef struct packed {
        logic [1:0]        kind;
        logic [0:15][7:0]  seq;   // values in read order
        logic [4:0]        tc;
        logic [1:0]        t1;
        logic [4:0]        tz;
        logic [4:0]        lvl;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [0:NV-1] = '{
        '{2'd0, {16{8'h00}}, 5'd0, 2'd0, 5'd0, 5'd0},
        '{2'd0, {8'h00,8'h00,8'h01,8'h00,8'hFF,8'h00,8'h00,8'h03,
                 8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h02}, 5'd4, 2'd2, 5'd10, 5'd2},
        '{2'd0, {8'hFF,8'h01,8'hFF,8'hFF,{12{8'h00}}}, 5'd4, 2'd3, 5'd12, 5'd1},
        '{2'd1, {8'h00,8'h05,8'h00,8'h00,8'hFF,8'h01,{10{8'h00}}}, 5'd3, 2'd0, 5'd11, 5'd3},
        '{2'd2, {8'h01,8'h00,8'h00,8'hFE,{12{8'h00}}}, 5'd2, 2'd1, 5'd2, 5'd1},
        '{2'd3, {16{8'h02}}, 5'd16, 2'd0, 5'd0, 5'd16},
        '{2'd0, {16{8'hFF}}, 5'd16, 2'd3, 5'd0, 5'd13}
    };

    localparam logic [0:15][3:0] RZ = {4'd15,4'd14,4'd11,4'd7,4'd10,4'd13,4'd12,4'd9,
                                       4'd6,4'd3,4'd2,4'd5,4'd8,4'd4,4'd1,4'd0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] blk_kind = 2'd0;
    logic rd_en, done;
    logic [3:0] rd_addr;
    logic [CW-1:0] rd_data;
    logic [4:0] total_coeff, total_zeros, level_cnt;
    logic [1:0] trailing_ones;
    logic [2:0] t1_signs;
    logic [15:0][CW-1:0] level_file;
    logic [15:0][3:0] run_file;

    logic [7:0] mem [16];
    int n_checks = 0;
    int n_fail = 0;
    int nrd = 0;
    logic [3:0] rec [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_data = {{(CW-8){mem[rd_addr][7]}}, mem[rd_addr]};

    coef_scan_analyzer #(.COEF_W(CW)) u_coef_scan_analyzer (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_kind(blk_kind),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
        .total_coeff(total_coeff), .trailing_ones(trailing_ones),
        .total_zeros(total_zeros), .level_cnt(level_cnt), .t1_signs(t1_signs),
        .level_file(level_file), .run_file(run_file)
    );

    always @(negedge clk) begin
        if (rd_en) begin
            if (nrd < 32) rec[nrd] = rd_addr;
            nrd = nrd + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int scan_len(input logic [1:0] k);
        return (k == 2'd2) ? 4 : (k == 2'd1) ? 15 : 16;
    endfunction

    function automatic logic [3:0] exp_addr(input logic [1:0] k, input int i);
        return (k == 2'd2) ? 4'(3 - i) : RZ[i];
    endfunction

    logic [15:0][CW-1:0] e_lvl;
    logic [15:0][3:0]    e_run;
    logic [2:0]          e_sgn;

    // reference model built from the requirements
    task automatic model(input vec_t v);
        int n, tc, t1, lv;
        bit open;
        logic [7:0] c;
        e_lvl = '0; e_run = '0; e_sgn = '0;
        n = scan_len(v.kind); tc = 0; t1 = 0; lv = 0; open = 1;
        for (int i = 0; i < n; i++) begin
            c = v.seq[i];
            if (c == 8'h00) begin
                if (tc > 0) e_run[tc-1] = e_run[tc-1] + 4'd1;
            end else begin
                tc++;
                if (open && (c == 8'h01 || c == 8'hFF) && t1 < 3) begin
                    e_sgn[t1] = (c == 8'hFF);
                    t1++;
                end else begin
                    open = 0;
                    e_lvl[lv] = {{(CW-8){c[7]}}, c};
                    lv++;
                end
            end
        end
    endtask

    task automatic run_vec(input int vi, input int poke);
        vec_t v;
        int n, k, bad;
        v = VEC[vi];
        n = scan_len(v.kind);
        for (int a = 0; a < 16; a++) mem[a] = 8'h09;
        for (int i = 0; i < n; i++) mem[exp_addr(v.kind, i)] = v.seq[i];
        model(v);
        nrd = 0;
        blk_kind = v.kind;
        start = 1'b1;
        k = 0;
        while (k < 40) begin
            @(negedge clk);
            k++;
            start = 1'b0;
            if (poke > 0 && k == poke) begin start = 1'b1; blk_kind = 2'd2; end
            if (done) break;
        end
        blk_kind = 2'd0;
        // R5 R11: done arrives the cycle after the last of n reads
        chk($sformatf("R11 done latency v%0d", vi), k, n + 1);
        chk($sformatf("R5 read count v%0d", vi), nrd, n);
        bad = 0;
        for (int i = 0; i < n && i < 32; i++) if (rec[i] != exp_addr(v.kind, i)) bad++;
        chk($sformatf("R2 R3 R4 address order v%0d", vi), bad, 0);
        chk($sformatf("R6 total_coeff v%0d", vi), total_coeff, v.tc);
        chk($sformatf("R7 trailing_ones v%0d", vi), trailing_ones, v.t1);
        chk($sformatf("R7 t1_signs v%0d", vi), t1_signs, e_sgn);
        chk($sformatf("R9 total_zeros v%0d", vi), total_zeros, v.tz);
        chk($sformatf("R8 level_cnt v%0d", vi), level_cnt, v.lvl);
        bad = 0;
        for (int j = 0; j < 16; j++) if (level_file[j] != e_lvl[j]) bad++;
        chk($sformatf("R8 level_file v%0d", vi), bad, 0);
        bad = 0;
        for (int j = 0; j < 16; j++) if (run_file[j] != e_run[j]) bad++;
        chk($sformatf("R10 run_file v%0d", vi), bad, 0);
        @(negedge clk);
        chk($sformatf("R11 done drops v%0d", vi), done, 0);
    endtask

    initial begin
        for (int a = 0; a < 16; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 counts", total_coeff + trailing_ones + total_zeros + level_cnt, 0);
        chk("R1 files", (level_file == '0) && (run_file == '0) && (t1_signs == '0), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", rd_en, 0);

        for (int vi = 0; vi < NV; vi++) run_vec(vi, 0);

        // R11 hold: results stay while idle even if buffer changes
        run_vec(1, 0);
        for (int a = 0; a < 16; a++) mem[a] = 8'h07;
        repeat (5) @(negedge clk);
        chk("R11 hold total_coeff", total_coeff, 4);
        chk("R11 hold total_zeros", total_zeros, 10);
        chk("R11 hold level0", level_file[0], 3);
        chk("R11 hold run2", run_file[2], 7);

        // R12 start during scan ignored
        run_vec(1, 3);
        run_vec(3, 10);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule